// File: doc/BRIEF.md
# Two-Event Join Synchronizer with Restart

This block waits for two independent one-cycle event pulses and announces, with a single-cycle strobe, the moment both have been seen. The events may come in either order, separated by any number of cycles, or together in one cycle. The strobe is raised combinationally in the same cycle as the event that completes the pair, so a downstream consumer can act without an extra cycle of latency. A typical use is committing a memory write once both the address and the data have arrived after a request opened the transaction.

Once the strobe has fired, the block sits idle and ignores further events until a restart pulse re-arms it. A restart always wins: in a cycle where restart is high, any event arriving in that same cycle is discarded and no strobe is produced. Internally, each awaited event owns one pending flag, and a single done flag records that the pair has been completed. The logic therefore grows with the number of events and not with the number of their orderings. The event count is a parameter, with a default of two.

Top module: `pair_join_sync`

## Requirements
- R1: Input `ev` carries one event per bit (bit 0 is event A, bit 1 is event B). `fire` is high in the same cycle as the event that completes the set, whichever event arrives last.
- R2: When A and B are both high in the same cycle while both are still awaited, `fire` is high in that cycle.
- R3: `fire` is high for exactly one cycle per completed pair. After it fires, no event produces `fire` again until a restart.
- R4: In a cycle with `restart` high, `fire` is low and the events present in that cycle are not recorded.
- R5: After a restart, both A and B must be seen again before the next `fire`. Progress made before the restart is forgotten.
- R6: A repeated pulse of an event that has already been recorded has no effect, and never produces `fire` while the other event is still outstanding.
- R7: While `rst` is high, `fire` is low. After `rst` is released, the block waits for both events, exactly as it does after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev | input | NUM_EV (2) | One-cycle event pulses, bit 0 = A, bit 1 = B |
| restart | input | 1 | Re-arm pulse, priority over `ev` |
| fire | output | 1 | One-cycle completion strobe |

## Verification
`fire` is a combinational function of the registered flags and the current inputs. Its result for a given stimulus is therefore due in the same cycle that stimulus is applied, and the flags that stimulus changes only affect the cycles after the next rising edge. The bench applies each cycle's inputs just after a falling edge and samples `fire` one time step later, well before the next rising edge. Each expected value is compared against the cycle that was just driven, and only then is the clock allowed to advance the state. Directed scenarios cover each ordering and priority case, and a seeded random sequence is compared cycle by cycle against a small model of pending and done bits.

// File: rtl/pair_join_pkg.sv
package pair_join_pkg;

    // State held for one awaited event.
    typedef struct packed {
        logic pend;
    } flag_state_t;

    // State held by the completion controller.
    typedef struct packed {
        logic done;
    } ctl_state_t;

    localparam flag_state_t FLAG_ARMED = '{pend: 1'b1};
    localparam ctl_state_t  CTL_IDLE   = '{done: 1'b0};

endpackage

// File: rtl/pend_flag.sv
module pend_flag
    import pair_join_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic halt,
    input  logic ev,
    output logic left
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = FLAG_ARMED;
        end else if (!halt) begin
            st_d.pend = st_q.pend & ~ev;
        end
        left = st_q.pend & ~ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= FLAG_ARMED;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a restart always re-arms the wait
    a_r5_restart_rearms: assert property (@(posedge clk) disable iff (rst)
        restart |=> st_q.pend);

    // R6: a pending wait is only cleared by its own event
    a_r6_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !ev) |=> st_q.pend);

    // R6: a cleared wait stays cleared until a restart
    a_r6_cleared_stays: assert property (@(posedge clk) disable iff (rst)
        (!st_q.pend && !restart) |=> !st_q.pend);

endmodule

// File: rtl/join_ctrl.sv
module join_ctrl
    import pair_join_pkg::*;
#(
    parameter int NUM_EV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [NUM_EV-1:0] left,
    output logic              done,
    output logic              fire
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = ~rst & ~restart & ~st_q.done & ~(|left);
        if (restart) begin
            st_d = CTL_IDLE;
        end else if (fire) begin
            st_d.done = 1'b1;
        end
        done = st_q.done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CTL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: once done, it stays done and silent until a restart
    a_r3_done_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q.done && !restart) |=> (st_q.done && !fire));

    // R5: a restart clears completion
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> !st_q.done);

endmodule

// File: rtl/pair_join_sync.sv
module pair_join_sync
    import pair_join_pkg::*;
#(
    parameter int NUM_EV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev,
    input  logic              restart,
    output logic              fire
);

    localparam int LAST_EV = NUM_EV - 1;

    logic [NUM_EV-1:0] left;
    logic              done;

    for (genvar g = 0; g <= LAST_EV; g++) begin : g_wait
        pend_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .halt    (done),
            .ev      (ev[g]),
            .left    (left[g])
        );
    end

    join_ctrl #(
        .NUM_EV (NUM_EV)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .left    (left),
        .done    (done),
        .fire    (fire)
    );

    // R3: the strobe never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R4: restart has priority over events
    a_r4_restart_wins: assert property (@(posedge clk) disable iff (rst)
        restart |-> !fire);

    // R1: the strobe needs at least one event in its cycle
    a_r1_needs_event: assert property (@(posedge clk) disable iff (rst)
        fire |-> (ev != '0));

    // R7: no strobe during reset
    always_comb begin
        if (rst) begin
            a_r7_quiet_in_reset: assert (!fire);
        end
    end

endmodule

// File: tb/test_pair_join_sync.sv
module test_pair_join_sync;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ev = 2'b00;
    logic       restart = 1'b0;
    logic       fire;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pair_join_sync i_pair_join_sync (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .restart (restart),
        .fire    (fire)
    );

    // Apply one cycle of stimulus and check fire within that cycle.
    task automatic cyc(input logic a, input logic b, input logic r,
                       input logic exp, input string req);
        @(negedge clk);
        ev = {b, a};
        restart = r;
        #1;
        total++;
        if (fire !== exp) begin
            bad++;
            $display("FAIL %s: a=%0b b=%0b r=%0b fire=%0b expected=%0b",
                     req, a, b, r, fire, exp);
        end
    endtask

    task automatic rearm();
        cyc(0, 0, 1, 0, "R4");
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        ev = 2'b11;
        restart = 1'b0;
        #1;
        total++;
        if (fire !== 1'b0) begin
            bad++;
            $display("FAIL R7: fire=%0b expected=0 during reset", fire);
        end
        @(negedge clk);
        rst = 1'b0;
        ev = 2'b00;
        // R7: after reset, a single event does not complete
        cyc(1, 0, 0, 0, "R7");
        cyc(0, 1, 0, 1, "R7");
    endtask

    task automatic t_a_then_b();
        rearm();
        cyc(1, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R1");
        cyc(0, 1, 0, 1, "R1");
        cyc(0, 0, 0, 0, "R3");
    endtask

    task automatic t_b_then_a();
        rearm();
        cyc(0, 1, 0, 0, "R1");
        cyc(1, 0, 0, 1, "R1");
    endtask

    task automatic t_same_cycle();
        rearm();
        cyc(1, 1, 0, 1, "R2");
        cyc(0, 0, 0, 0, "R3");
    endtask

    task automatic t_halt_after_fire();
        rearm();
        cyc(1, 1, 0, 1, "R2");
        cyc(1, 1, 0, 0, "R3");
        cyc(1, 0, 0, 0, "R3");
        cyc(0, 1, 0, 0, "R3");
    endtask

    task automatic t_priority();
        rearm();
        cyc(1, 0, 0, 0, "R4");
        // B together with restart: suppressed and discarded
        cyc(0, 1, 1, 0, "R4");
        cyc(0, 0, 0, 0, "R4");
        // A and B with restart: discarded
        cyc(1, 1, 1, 0, "R4");
        cyc(1, 0, 0, 0, "R4");
        cyc(0, 1, 0, 1, "R4");
    endtask

    task automatic t_forget();
        rearm();
        cyc(0, 1, 0, 0, "R5");
        rearm();
        cyc(1, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, "R5");
        cyc(0, 1, 0, 1, "R5");
    endtask

    task automatic t_repeat();
        rearm();
        cyc(1, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, "R6");
        cyc(1, 0, 0, 0, "R6");
        cyc(0, 1, 0, 1, "R6");
        rearm();
        cyc(0, 1, 0, 0, "R6");
        cyc(0, 1, 0, 0, "R6");
        cyc(1, 1, 0, 1, "R6");
    endtask

    // Random sequence against a pending/done model (R1..R6).
    task automatic t_random();
        logic pa = 1'b1;
        logic pb = 1'b1;
        logic dn = 1'b0;
        rearm();
        for (int i = 0; i < 400; i++) begin
            logic a = ($urandom_range(3) == 0);
            logic b = ($urandom_range(3) == 0);
            logic r = ($urandom_range(7) == 0);
            logic exp = 1'b0;
            if (r) begin
                pa = 1'b1;
                pb = 1'b1;
                dn = 1'b0;
            end else if (!dn) begin
                pa = pa & ~a;
                pb = pb & ~b;
                exp = !pa && !pb;
                dn = exp;
            end
            cyc(a, b, r, exp, "R1-random");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_a_then_b();
        t_b_then_a();
        t_same_cycle();
        t_halt_after_fire();
        t_priority();
        t_forget();
        t_repeat();
        t_random();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule